// File: doc/BRIEF.md
# PCIe TLP Trace Filter and Capture

This block sits beside a PCIe root complex and watches a stream of TLP header events. Each event states its class (posted, non-posted or completion), whether it travels outbound or inbound, which of two completion sub-kinds it belongs to, four header dwords and a 32-bit timestamp. A class mask and a direction code decide which events are kept. The direction code is read one way when filtering by port and another way when filtering by requester.

Each kept event becomes a trace entry of 4 or 8 dwords. The entry leaves the block as one registered write request with a valid/ready handshake. Entries fill a ring of four equal-size buffers in the order 0, 1, 2, 3 and then wrap back to buffer 0. A one-cycle pulse marks each buffer that is closed. An event that arrives while the write port is stalled is dropped and sets a sticky overflow flag.

Configuration is captured only while tracing is off, so software changes made during a run have no effect. Turning tracing on restarts the ring at the start of buffer 0.

Top module: `tlp_trace_capture`

## Requirements
- R1: An event with `ev_valid` high is traced only if its class bit is set in `cfg_type_mask` and the direction rule passes. The class codes are 00 posted, 01 non-posted and 10 completion, mapped to mask bits 0, 1 and 2. Class code 11 is never traced.
- R2: With `cfg_req_mode`=0 (port filtering), the direction code selects what is traced:
  - 0000: every inbound event.
  - 0001: every outbound event.
  - 0010: every outbound event, plus inbound posted, non-posted and sub-kind-B completions.
  - 0011: every outbound event, plus inbound sub-kind-A completions.
  - Any other code: nothing.
- R3: With `cfg_req_mode`=1 (requester filtering), the direction code selects what is traced:
  - 0000: nothing (reserved).
  - 0001: every outbound event.
  - 0010: inbound posted, non-posted and sub-kind-B completions.
  - 0011: inbound sub-kind-A completions.
  - Any other code: nothing.
- R4: `ev_cpl_b`=1 marks a completion as sub-kind B and 0 marks it as sub-kind A. The flag matters only for inbound completions under codes 0010 and 0011.
- R5: `cfg_format` 0000 gives a 4-dword entry: dword 0 is the timestamp and dwords 1 to 3 are header dwords 0 to 2. Code 0001 gives an 8-dword entry: dwords 0 to 3 are header dwords 0 to 3, dword 4 is the timestamp, and dword 5 is {28 zero bits, cpl_b, outbound, class[1:0]}. All unused dwords are zero. Dword k is at `wr_data[32k+31:32k]` and header dword k is at `ev_hdr[32k+31:32k]`. `wr_wide` is 1 for an 8-dword entry. Any other format code traces nothing.
- R6: A traced event sampled at a clock edge appears on the write port after that edge. Its address is the base of the current buffer plus the running byte offset. Entries in one buffer are contiguous, 16 or 32 bytes apart. Base k is `cfg_buf_base[32k+31:32k]` at the default width.
- R7: An entry is never split across buffers. When the entry just issued leaves less room than one more entry before `cfg_buf_size`, `buf_done` pulses for one cycle with that buffer's index on `buf_done_idx`. The next entry then starts at the base of the next buffer, and buffer 3 is followed by buffer 0.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged.
- R9: A traced event that arrives while the write port is stalled is dropped. The drop sets `overflow`, which stays set. The dropped event does not advance the write position.
- R10: Configuration inputs are ignored while tracing is on. The rising edge of `cfg_enable` restarts writing at the base of buffer 0 and clears `overflow`.
- R11: After reset, `wr_valid`, `buf_done` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Tracing on |
| cfg_req_mode | input | 1 | 0 port filtering, 1 requester filtering |
| cfg_type_mask | input | 8 | Class mask |
| cfg_dir_code | input | 4 | Direction code |
| cfg_format | input | 4 | Entry format code |
| cfg_buf_base | input | 4*ADDR_W | Four buffer base addresses |
| cfg_buf_size | input | SIZE_W | Bytes per buffer |
| ev_valid | input | 1 | Event present this cycle |
| ev_class | input | 2 | Event class |
| ev_outbound | input | 1 | 1 outbound, 0 inbound |
| ev_cpl_b | input | 1 | Completion sub-kind B |
| ev_hdr | input | 128 | Header dwords 0 to 3 |
| ev_ts | input | 32 | Timestamp |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Entry byte address |
| wr_data | output | 256 | Entry data |
| wr_wide | output | 1 | Entry is 8 dwords |
| buf_done | output | 1 | Buffer closed pulse |
| buf_done_idx | output | 2 | Index of the closed buffer |
| overflow | output | 1 | Sticky drop flag |

## Verification
The assertions check the cycle-level rules on every cycle:
- the write port holds its request while stalled;
- a stalled hit always raises the overflow flag, and the flag stays sticky;
- requester code 0000 never matches;
- a buffer-done pulse always comes with a write;
- no new write starts while tracing is off.

Only the bench's scenarios can show the rest. That covers the direction tables under each class and sub-kind, the exact entry layouts, and the address sequence across buffers, including the wrap from buffer 3 to 0 and sizes that are not a whole number of entries. It also covers that a dropped event does not move the pointer, and that configuration changed during a run is ignored.

// File: rtl/tlp_trace_pkg.sv
// Shared constants for the trace capture block.
// Assumes a ring of exactly four buffers and 32-bit dwords.
package tlp_trace_pkg;
    localparam int NUM_BUFS  = 4;
    localparam int IDX_W     = $clog2(NUM_BUFS);
    localparam int DW_BITS   = 32;
    localparam int HDR_DWS   = 4;
    localparam int MAX_DWS   = 8;
    localparam int HDR_W     = HDR_DWS * DW_BITS;
    localparam int DATA_W    = MAX_DWS * DW_BITS;

    localparam logic [1:0] CLS_POSTED = 2'd0;
    localparam logic [1:0] CLS_NONPOS = 2'd1;
    localparam logic [1:0] CLS_CPL    = 2'd2;

    localparam logic [3:0] FMT_NARROW = 4'd0;
    localparam logic [3:0] FMT_WIDE   = 4'd1;

    localparam logic [3:0] DIR_C0 = 4'd0;
    localparam logic [3:0] DIR_C1 = 4'd1;
    localparam logic [3:0] DIR_C2 = 4'd2;
    localparam logic [3:0] DIR_C3 = 4'd3;
endpackage

// File: rtl/tlp_trace_match.sv
// Decides whether one event is traced under the current filter settings.
// Purely combinational; the caller qualifies the result with event valid.
module tlp_trace_match
    import tlp_trace_pkg::*;
(
    input  logic       req_mode,
    input  logic [7:0] type_mask,
    input  logic [3:0] dir_code,
    input  logic       fmt_ok,
    input  logic [1:0] cls,
    input  logic       outbound,
    input  logic       cpl_b,
    output logic       hit
);
    logic [7:0] cls_sel;
    logic       cls_ok;
    logic       is_cpl;
    logic       in_pnp_b;
    logic       in_cpl_a;
    logic       dir_ok;

    // Class gate: one-hot select of the event class against the mask.
    always_comb begin
        cls_sel  = 8'(1) << cls;
        cls_ok   = (cls != 2'd3) && |(cls_sel & type_mask);
        is_cpl   = (cls == CLS_CPL);
        in_pnp_b = !outbound && (!is_cpl || cpl_b);
        in_cpl_a = !outbound && is_cpl && !cpl_b;
    end

    // Direction gate: the code is read differently in the two filter kinds.
    always_comb begin
        dir_ok = 1'b0;
        if (!req_mode) begin
            case (dir_code)
                DIR_C0:  dir_ok = !outbound;
                DIR_C1:  dir_ok = outbound;
                DIR_C2:  dir_ok = outbound || in_pnp_b;
                DIR_C3:  dir_ok = outbound || in_cpl_a;
                default: dir_ok = 1'b0;
            endcase
        end else begin
            case (dir_code)
                DIR_C1:  dir_ok = outbound;
                DIR_C2:  dir_ok = in_pnp_b;
                DIR_C3:  dir_ok = in_cpl_a;
                default: dir_ok = 1'b0;
            endcase
        end
    end

    assign hit = fmt_ok && cls_ok && dir_ok;
endmodule

// File: rtl/tlp_trace_pack.sv
// Builds a trace entry from one event in the 4- or 8-dword layout.
// Unused dwords are zero; dword k sits at bits [32k +: 32].
module tlp_trace_pack
    import tlp_trace_pkg::*;
(
    input  logic              wide,
    input  logic [HDR_W-1:0]  hdr,
    input  logic [31:0]       ts,
    input  logic [1:0]        cls,
    input  logic              outbound,
    input  logic              cpl_b,
    output logic [DATA_W-1:0] entry
);
    logic [DW_BITS-1:0] dw [MAX_DWS];

    // Layout selection: narrow puts the timestamp first, wide appends it after the header.
    always_comb begin
        for (int i = 0; i < MAX_DWS; i++) dw[i] = '0;
        if (wide) begin
            for (int i = 0; i < HDR_DWS; i++) dw[i] = hdr[i*DW_BITS +: DW_BITS];
            dw[4] = ts;
            dw[5] = {28'd0, cpl_b, outbound, cls};
        end else begin
            dw[0] = ts;
            for (int i = 1; i < HDR_DWS; i++) dw[i] = hdr[(i-1)*DW_BITS +: DW_BITS];
        end
    end

    for (genvar g = 0; g < MAX_DWS; g++) begin : g_flat
        assign entry[g*DW_BITS +: DW_BITS] = dw[g];
    end
endmodule

// File: rtl/tlp_trace_ptr.sv
// Tracks the current buffer and byte offset within the four-buffer ring.
// Assumes the buffer size is at least one entry; a tail too short for an entry is skipped.
module tlp_trace_ptr
    import tlp_trace_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 32
)(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         advance,
    input  logic                         wide,
    input  logic [NUM_BUFS*ADDR_W-1:0]   base_flat,
    input  logic [SIZE_W-1:0]            size,
    output logic [ADDR_W-1:0]            cur_addr,
    output logic                         cur_last,
    output logic [IDX_W-1:0]             cur_idx
);
    logic [ADDR_W-1:0] base_arr [NUM_BUFS];
    logic [SIZE_W-1:0] offset;
    logic [SIZE_W:0]   ent_bytes;
    logic [SIZE_W:0]   need;

    for (genvar g = 0; g < NUM_BUFS; g++) begin : g_base
        assign base_arr[g] = base_flat[g*ADDR_W +: ADDR_W];
    end

    // Room test: the buffer closes when a further entry would not fit.
    always_comb begin
        ent_bytes = wide ? (SIZE_W+1)'(32) : (SIZE_W+1)'(16);
        need      = {1'b0, offset} + (ent_bytes << 1);
        cur_last  = need > {1'b0, size};
        cur_addr  = base_arr[cur_idx] + ADDR_W'(offset);
    end

    // Position update: step within the buffer or move to the next one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cur_idx <= '0;
            offset  <= '0;
        end else if (advance) begin
            if (cur_last) begin
                cur_idx <= (cur_idx == IDX_W'(NUM_BUFS-1)) ? '0 : cur_idx + 1'b1;
                offset  <= '0;
            end else begin
                offset  <= offset + ent_bytes[SIZE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/tlp_trace_capture.sv
// Top of the trace capture block: filters events, packs entries and issues one write each.
// Configuration is sampled only while tracing is off; one write can be outstanding.
module tlp_trace_capture
    import tlp_trace_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 32
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_enable,
    input  logic                       cfg_req_mode,
    input  logic [7:0]                 cfg_type_mask,
    input  logic [3:0]                 cfg_dir_code,
    input  logic [3:0]                 cfg_format,
    input  logic [NUM_BUFS*ADDR_W-1:0] cfg_buf_base,
    input  logic [SIZE_W-1:0]          cfg_buf_size,
    input  logic                       ev_valid,
    input  logic [1:0]                 ev_class,
    input  logic                       ev_outbound,
    input  logic                       ev_cpl_b,
    input  logic [HDR_W-1:0]           ev_hdr,
    input  logic [31:0]                ev_ts,
    output logic                       wr_valid,
    input  logic                       wr_ready,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [DATA_W-1:0]          wr_data,
    output logic                       wr_wide,
    output logic                       buf_done,
    output logic [IDX_W-1:0]           buf_done_idx,
    output logic                       overflow
);
    logic                       trace_on;
    logic                       sh_req;
    logic [7:0]                 sh_mask;
    logic [3:0]                 sh_dir;
    logic [3:0]                 sh_fmt;
    logic [NUM_BUFS*ADDR_W-1:0] sh_base;
    logic [SIZE_W-1:0]          sh_size;
    logic                       fmt_ok;
    logic                       fmt_wide;
    logic                       hit;
    logic                       stalled;
    logic                       take;
    logic [DATA_W-1:0]          entry;
    logic [ADDR_W-1:0]          cur_addr;
    logic                       cur_last;
    logic [IDX_W-1:0]           cur_idx;

    // Run state: registered copy of the enable input.
    always_ff @(posedge clk) begin
        if (!rst_n) trace_on <= 1'b0;
        else        trace_on <= cfg_enable;
    end

    // Configuration shadow: follows the inputs only while tracing is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_req  <= 1'b0;
            sh_mask <= '0;
            sh_dir  <= '0;
            sh_fmt  <= '0;
            sh_base <= '0;
            sh_size <= '0;
        end else if (!trace_on) begin
            sh_req  <= cfg_req_mode;
            sh_mask <= cfg_type_mask;
            sh_dir  <= cfg_dir_code;
            sh_fmt  <= cfg_format;
            sh_base <= cfg_buf_base;
            sh_size <= cfg_buf_size;
        end
    end

    assign fmt_wide = (sh_fmt == FMT_WIDE);
    assign fmt_ok   = (sh_fmt == FMT_NARROW) || fmt_wide;

    tlp_trace_match u_match (
        .req_mode  (sh_req),
        .type_mask (sh_mask),
        .dir_code  (sh_dir),
        .fmt_ok    (fmt_ok),
        .cls       (ev_class),
        .outbound  (ev_outbound),
        .cpl_b     (ev_cpl_b),
        .hit       (hit)
    );

    tlp_trace_pack u_pack (
        .wide     (fmt_wide),
        .hdr      (ev_hdr),
        .ts       (ev_ts),
        .cls      (ev_class),
        .outbound (ev_outbound),
        .cpl_b    (ev_cpl_b),
        .entry    (entry)
    );

    assign stalled = wr_valid && !wr_ready;
    assign take    = trace_on && ev_valid && hit && !stalled;

    tlp_trace_ptr #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!trace_on),
        .advance   (take),
        .wide      (fmt_wide),
        .base_flat (sh_base),
        .size      (sh_size),
        .cur_addr  (cur_addr),
        .cur_last  (cur_last),
        .cur_idx   (cur_idx)
    );

    // Write request register: loads a new entry or retires the accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_wide  <= 1'b0;
        end else if (take) begin
            wr_valid <= 1'b1;
            wr_addr  <= cur_addr;
            wr_data  <= entry;
            wr_wide  <= fmt_wide;
        end else if (wr_ready) begin
            wr_valid <= 1'b0;
        end
    end

    // Buffer close pulse: one cycle, alongside the last entry of a buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_done     <= 1'b0;
            buf_done_idx <= '0;
        end else begin
            buf_done <= take && cur_last;
            if (take) buf_done_idx <= cur_idx;
        end
    end

    // Drop flag: set on a stalled hit, cleared when tracing starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                           overflow <= 1'b0;
        else if (cfg_enable && !trace_on)     overflow <= 1'b0;
        else if (trace_on && ev_valid && hit && stalled) overflow <= 1'b1;
    end
endmodule

// File: rtl/tlp_trace_capture_chk.sv
// Cycle-level checks for the trace capture block, bound into the top.
module tlp_trace_capture_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 256
)(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic              trace_on,
    input logic              hit,
    input logic              ev_valid,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              buf_done,
    input logic              overflow,
    input logic              sh_req,
    input logic [3:0]        sh_dir
);
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R8
    AST_DROP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        trace_on && ev_valid && hit && wr_valid && !wr_ready |=> overflow); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !(cfg_enable && !trace_on) |=> overflow); // R9
    AST_RSV_CODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        trace_on && sh_req && sh_dir == 4'd0 |-> !hit); // R3
    AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |-> wr_valid); // R7
    AST_LOAD_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(trace_on)); // R10
endmodule

bind tlp_trace_capture tlp_trace_capture_chk #(.ADDR_W(ADDR_W), .DATA_W(tlp_trace_pkg::DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .trace_on   (trace_on),
    .hit        (hit),
    .ev_valid   (ev_valid),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .buf_done   (buf_done),
    .overflow   (overflow),
    .sh_req     (sh_req),
    .sh_dir     (sh_dir)
);

// File: tb/tlp_trace_capture_tb.sv
module tlp_trace_capture_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_enable = 1'b0;
    logic         cfg_req_mode = 1'b0;
    logic [7:0]   cfg_type_mask = '0;
    logic [3:0]   cfg_dir_code = '0;
    logic [3:0]   cfg_format = '0;
    logic [127:0] cfg_buf_base = '0;
    logic [31:0]  cfg_buf_size = '0;
    logic         ev_valid = 1'b0;
    logic [1:0]   ev_class = '0;
    logic         ev_outbound = 1'b0;
    logic         ev_cpl_b = 1'b0;
    logic [127:0] ev_hdr = '0;
    logic [31:0]  ev_ts = '0;
    logic         wr_valid;
    logic         wr_ready = 1'b1;
    logic [31:0]  wr_addr;
    logic [255:0] wr_data;
    logic         wr_wide;
    logic         buf_done;
    logic [1:0]   buf_done_idx;
    logic         overflow;

    int total = 0;
    int bad = 0;

    logic        m_req;
    logic [7:0]  m_mask;
    logic [3:0]  m_dir;
    logic [3:0]  m_fmt;
    longint      m_size;
    logic [31:0] m_base [4];
    int          m_idx;
    longint      m_off;

    always #10 clk = ~clk;

    tlp_trace_capture u_dut (.*);

    task automatic check(input string rq, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic exp_hit(input logic [1:0] c, input logic o, input logic b);
        logic in_pnp_b, in_cpl_a;
        if (m_fmt > 4'd1 || c == 2'd3 || !m_mask[c]) return 1'b0;
        in_pnp_b = !o && (c != 2'd2 || b);
        in_cpl_a = !o && c == 2'd2 && !b;
        if (!m_req) begin
            case (m_dir)
                4'd0: return !o;
                4'd1: return o;
                4'd2: return o || in_pnp_b;
                4'd3: return o || in_cpl_a;
                default: return 1'b0;
            endcase
        end
        case (m_dir)
            4'd1: return o;
            4'd2: return in_pnp_b;
            4'd3: return in_cpl_a;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [255:0] exp_data(input logic [1:0] c, input logic o, input logic b,
                                              input logic [127:0] h, input logic [31:0] t);
        logic [255:0] d = '0;
        if (m_fmt == 4'd1) begin
            d[127:0]   = h;
            d[159:128] = t;
            d[191:160] = {28'd0, b, o, c};
        end else begin
            d[31:0]  = t;
            d[127:32] = h[95:0];
        end
        return d;
    endfunction

    task automatic configure(input logic rq, input logic [7:0] mk, input logic [3:0] dr,
                             input logic [3:0] fm, input longint sz);
        cfg_enable = 1'b0;
        ev_valid = 1'b0;
        @(negedge clk);
        cfg_req_mode = rq; cfg_type_mask = mk; cfg_dir_code = dr; cfg_format = fm;
        cfg_buf_size = 32'(sz);
        cfg_buf_base = {m_base[3], m_base[2], m_base[1], m_base[0]};
        m_req = rq; m_mask = mk; m_dir = dr; m_fmt = fm; m_size = sz;
        m_idx = 0; m_off = 0;
        @(negedge clk);
        cfg_enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input logic [1:0] c, input logic o, input logic b,
                        input logic [127:0] h, input logic [31:0] t, input string rq);
        logic   hit;
        longint eb;
        logic   last;
        ev_valid = 1'b1; ev_class = c; ev_outbound = o; ev_cpl_b = b; ev_hdr = h; ev_ts = t;
        @(negedge clk);
        ev_valid = 1'b0;
        hit = exp_hit(c, o, b);
        check(rq, 256'(wr_valid), 256'(hit));
        if (hit) begin
            eb = (m_fmt == 4'd1) ? 32 : 16;
            last = (m_off + 2 * eb) > m_size;
            check("R6", 256'(wr_addr), 256'(m_base[m_idx] + 32'(m_off)));
            check("R5", wr_data, exp_data(c, o, b, h, t));
            check("R5", 256'(wr_wide), 256'(m_fmt == 4'd1));
            check("R7", 256'(buf_done), 256'(last));
            if (last) check("R7", 256'(buf_done_idx), 256'(m_idx));
            if (last) begin m_idx = (m_idx + 1) % 4; m_off = 0; end
            else m_off = m_off + eb;
        end else begin
            check("R7", 256'(buf_done), 256'(0));
        end
    endtask

    function automatic logic [127:0] rnd_hdr();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_base[0] = 32'h1000_0000; m_base[1] = 32'h2000_0000;
        m_base[2] = 32'h3000_0000; m_base[3] = 32'h4000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", 256'(wr_valid), 256'(0));
        check("R11", 256'(buf_done), 256'(0));
        check("R11", 256'(overflow), 256'(0));

        // R2 R3 R4: every class, direction and sub-kind under each code, both filter kinds.
        for (int md = 0; md < 2; md++) begin
            for (int dc = 0; dc < 5; dc++) begin
                configure(md[0], 8'h07, 4'(dc), 4'd0, 64'd4194304);
                for (int c = 0; c < 4; c++)
                    for (int o = 0; o < 2; o++)
                        for (int b = 0; b < 2; b++)
                            send(2'(c), o[0], b[0], rnd_hdr(), $urandom, md ? "R3" : "R2");
            end
        end

        // R1: mask with only the non-posted bit set.
        configure(1'b0, 8'h02, 4'd1, 4'd0, 64'd4194304);
        for (int c = 0; c < 4; c++) send(2'(c), 1'b1, 1'b0, rnd_hdr(), $urandom, "R1");

        // R5: wide layout, and a reserved format code that traces nothing.
        configure(1'b0, 8'h07, 4'd1, 4'd1, 64'd4194304);
        for (int c = 0; c < 3; c++) send(2'(c), 1'b1, 1'b1, rnd_hdr(), $urandom, "R5");
        configure(1'b0, 8'h07, 4'd1, 4'd2, 64'd4194304);
        send(2'd0, 1'b1, 1'b0, rnd_hdr(), $urandom, "R5");

        // R7: four entries per buffer, through a full wrap.
        configure(1'b0, 8'h07, 4'd1, 4'd0, 64'd64);
        for (int i = 0; i < 17; i++) send(2'd0, 1'b1, 1'b0, rnd_hdr(), $urandom, "R7");
        // R7: size not a whole number of wide entries.
        configure(1'b0, 8'h07, 4'd1, 4'd1, 64'd40);
        for (int i = 0; i < 5; i++) send(2'd1, 1'b1, 1'b0, rnd_hdr(), $urandom, "R7");

        // R10: configuration changed while running is ignored.
        configure(1'b0, 8'h07, 4'd1, 4'd0, 64'd4194304);
        cfg_type_mask = 8'h00; cfg_format = 4'd1; cfg_dir_code = 4'd0;
        for (int i = 0; i < 3; i++) send(2'(i), 1'b1, 1'b0, rnd_hdr(), $urandom, "R10");

        // R8 R9: stall holds the request, drops the next hit and sets the flag.
        configure(1'b0, 8'h07, 4'd1, 4'd0, 64'd4194304);
        wr_ready = 1'b0;
        send(2'd0, 1'b1, 1'b0, 128'hA, 32'h11, "R6");
        ev_valid = 1'b1; ev_class = 2'd1; ev_outbound = 1'b1; ev_hdr = 128'hB; ev_ts = 32'h22;
        @(negedge clk);
        ev_valid = 1'b0;
        check("R9", 256'(overflow), 256'(1));
        check("R8", 256'(wr_valid), 256'(1));
        check("R8", 256'(wr_addr), 256'(m_base[0]));
        check("R8", wr_data[31:0], 256'(32'h11));
        wr_ready = 1'b1;
        @(negedge clk);
        check("R8", 256'(wr_valid), 256'(0));
        send(2'd2, 1'b1, 1'b0, rnd_hdr(), $urandom, "R9");
        check("R9", 256'(overflow), 256'(1));
        configure(1'b0, 8'h07, 4'd1, 4'd0, 64'd4194304);
        check("R10", 256'(overflow), 256'(0));
        send(2'd0, 1'b1, 1'b0, rnd_hdr(), $urandom, "R10");

        // R1: random settings and traffic.
        for (int k = 0; k < 8; k++) begin
            longint sz;
            case ($urandom % 4)
                0: sz = 48; 1: sz = 64; 2: sz = 100; default: sz = 4194304;
            endcase
            configure(1'($urandom), 8'($urandom), 4'($urandom % 5), 4'($urandom % 3), sz);
            for (int i = 0; i < 60; i++)
                send(2'($urandom), 1'($urandom), 1'($urandom), rnd_hdr(), $urandom, "R1");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule